// File: doc/BRIEF.md
# Transmit Fatal-Error Interrupt and Resync Controller

This block gathers eight exception events of a transmit link interface into a sticky status register. The events are a calendar parity error in bank 0, a calendar parity error in bank 1, an oversized burst, a FIFO overflow, a DIP2 error, DIP2 loss of sync, an unexpected framing pattern and framing loss. Two separately programmed masks act on these events. The interrupt mask selects which status bits drive the interrupt line. The fatal mask selects which events take the link down.

A fatal event sets a ninth status bit, the sync error. It also holds the transmit datapath stopped with continuous training forced. Software recovers the link by clearing the sync error and then taking the interface enable low and back high. Each time the enable falls, a one-cycle credit-flush pulse cancels all accumulated credits. The oversized-burst event comes from a built-in beat counter that watches each burst. Calendar table accesses are granted only while the interface is disabled.

Top module: `txerr_resync_ctrl`

## Requirements
- R1: Event `evt_i[k]` sets `status_o[k]` on the clock edge that samples it. The bit order is: 0 calendar parity bank 0, 1 calendar parity bank 1, 2 burst too big, 3 FIFO overflow, 4 DIP2 error, 5 DIP2 loss of sync, 6 unexpected framing, 7 framing loss. Bit 8 is the sync error.
- R2: Status bits are sticky. A register write with `reg_sel_i`=1 clears each status bit whose `reg_wdata_i` bit is 1. If a bit is set and cleared in the same cycle, the set wins.
- R3: `irq_o` equals the OR over bits 0..7 of the status ANDed with the interrupt mask, delayed by one register stage. The interrupt mask is written with `reg_sel_i`=2 from `reg_wdata_i[7:0]`.
- R4: An event whose fatal-mask bit is set sets status bit 8 and `train_o` on the next edge, and forces `dp_run_o` to 0. The fatal mask is written with `reg_sel_i`=3 from `reg_wdata_i[7:0]`. An event whose fatal-mask bit is clear changes neither.
- R5: `train_o` clears only after status bit 8 has been cleared, then the interface enable has been seen at 0, and then the enable is seen at 1. Toggling the enable while bit 8 is still set does not release training.
- R6: `credit_flush_o` pulses high for one cycle, in the cycle right after the interface enable goes from 1 to 0.
- R7: `cal_ok_o` equals `cal_req_i` while the interface is disabled, and is 0 while it is enabled.
- R8: Within one burst, a beat that takes the burst beyond MAX_BURST_BYTES (default 512 KB, 8-byte beats) raises the burst-too-big event on status bit 2. A burst of exactly the limit does not raise it. A beat with `beat_last_i` ends the burst.
- R9: A register write with `reg_sel_i`=0 loads the interface enable from `reg_wdata_i[0]` and the status-channel enable from `reg_wdata_i[3]`. `dp_run_o` is 1 only while the interface is enabled and not training.
- R10: After reset, the status, both masks, `irq_o`, both enables, `train_o`, `dp_run_o` and `credit_flush_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 8 | Exception event pulses, bit order as in R1 |
| beat_i | input | 1 | One data beat transmitted |
| beat_last_i | input | 1 | The beat ends its burst |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Write target: 0 control, 1 status clear, 2 interrupt mask, 3 fatal mask |
| reg_wdata_i | input | 9 | Write data |
| cal_req_i | input | 1 | Calendar table access request |
| status_o | output | 9 | Sticky status, bit 8 is the sync error |
| irq_o | output | 1 | Interrupt line |
| inf_en_o | output | 1 | Interface enable |
| stat_en_o | output | 1 | Status-channel enable |
| train_o | output | 1 | Continuous training forced |
| dp_run_o | output | 1 | Transmit datapath running |
| credit_flush_o | output | 1 | Cancel accumulated credits |
| cal_ok_o | output | 1 | Calendar access granted |

## Verification
Each event bit is pulsed alone with both masks clear. This separates the bit mapping from any interrupt or fatal side effect. Events are then applied with the interrupt mask and the fatal mask set on different bits, so an event that should only interrupt is told apart from one that should take the link down. The recovery sequence is run twice: once with the enable toggled before the sync error is cleared, where training must remain, and once in the correct order, where training must release. A long random mix of events, register writes, beats and calendar requests is checked cycle by cycle against a bench model. Bursts of exactly the limit and one beat over it test the oversized-burst boundary.

// File: rtl/ters_pkg.sv
package ters_pkg;
    localparam int NUM_EVT      = 8;
    localparam int STAT_W       = NUM_EVT + 1;
    localparam int EV_BURST_BIG = 2;        // bit driven by the burst monitor
    localparam int SYNCERR_BIT  = NUM_EVT;  // status-only fatal summary bit

    typedef enum logic [1:0] {
        SEL_CTL   = 2'd0,
        SEL_STAT  = 2'd1,
        SEL_IMASK = 2'd2,
        SEL_FMASK = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/ters_burst_mon.sv
module ters_burst_mon #(
    parameter int MAX_BURST_BYTES = 524288,
    parameter int BEAT_BYTES      = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic beat_i,
    input  logic last_i,
    output logic too_big_o
);
    localparam int LIMIT_BEATS = MAX_BURST_BYTES / BEAT_BYTES;
    localparam int CNT_W       = $clog2(LIMIT_BEATS + 1);
    localparam logic [CNT_W-1:0] LIMIT_C = CNT_W'(LIMIT_BEATS);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        too_big_o = beat_i && (s_q.cnt == LIMIT_C);
        if (beat_i) begin
            if (last_i)
                s_d.cnt = '0;
            else if (s_q.cnt != LIMIT_C)
                s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/ters_evt_status.sv
module ters_evt_status
    import ters_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic              we_i,
    input  logic [1:0]        sel_i,
    input  logic [STAT_W-1:0] wdata_i,
    output logic [STAT_W-1:0] status_o,
    output logic [NUM_EVT-1:0] imask_o,
    output logic [NUM_EVT-1:0] fmask_o,
    output logic              irq_o,
    output logic              fatal_o
);
    typedef struct packed {
        logic [STAT_W-1:0]  status;
        logic [NUM_EVT-1:0] imask;
        logic [NUM_EVT-1:0] fmask;
        logic               irq;
    } state_t;

    state_t            s_d, s_q;
    logic [STAT_W-1:0] clr;
    logic              fatal;

    always_comb begin
        s_d   = s_q;
        fatal = |(evt_i & s_q.fmask);
        clr   = (we_i && sel_i == SEL_STAT) ? wdata_i : '0;
        // set has priority over write-one-to-clear
        s_d.status[NUM_EVT-1:0] = (s_q.status[NUM_EVT-1:0] & ~clr[NUM_EVT-1:0]) | evt_i;
        s_d.status[SYNCERR_BIT] = (s_q.status[SYNCERR_BIT] & ~clr[SYNCERR_BIT]) | fatal;
        if (we_i && sel_i == SEL_IMASK) s_d.imask = wdata_i[NUM_EVT-1:0];
        if (we_i && sel_i == SEL_FMASK) s_d.fmask = wdata_i[NUM_EVT-1:0];
        s_d.irq = |(s_q.status[NUM_EVT-1:0] & s_q.imask);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign status_o = s_q.status;
    assign imask_o  = s_q.imask;
    assign fmask_o  = s_q.fmask;
    assign irq_o    = s_q.irq;
    assign fatal_o  = fatal;
endmodule

// File: rtl/ters_sync_ctl.sv
module ters_sync_ctl
    import ters_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we_i,
    input  logic [1:0] sel_i,
    input  logic       ifen_wr_i,
    input  logic       sten_wr_i,
    input  logic       fatal_i,
    input  logic       syncerr_i,
    input  logic       cal_req_i,
    output logic       inf_en_o,
    output logic       stat_en_o,
    output logic       train_o,
    output logic       dp_run_o,
    output logic       credit_flush_o,
    output logic       cal_ok_o
);
    typedef struct packed {
        logic inf_en;
        logic stat_en;
        logic train;
        logic armed;   // syncerr cleared and enable seen low while training
        logic flush;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (we_i && sel_i == SEL_CTL) begin
            s_d.inf_en  = ifen_wr_i;
            s_d.stat_en = sten_wr_i;
        end
        s_d.flush = s_q.inf_en & ~s_d.inf_en;
        s_d.armed = s_q.train & ~fatal_i &
                    (s_q.armed | (~syncerr_i & ~s_q.inf_en));
        s_d.train = fatal_i | (s_q.train & ~(s_q.armed & s_q.inf_en));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign inf_en_o       = s_q.inf_en;
    assign stat_en_o      = s_q.stat_en;
    assign train_o        = s_q.train;
    assign dp_run_o       = s_q.inf_en & ~s_q.train;
    assign credit_flush_o = s_q.flush;
    assign cal_ok_o       = cal_req_i & ~s_q.inf_en;
endmodule

// File: rtl/txerr_resync_ctrl.sv
module txerr_resync_ctrl
    import ters_pkg::*;
#(
    parameter int MAX_BURST_BYTES = 524288,
    parameter int BEAT_BYTES      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic              beat_i,
    input  logic              beat_last_i,
    input  logic              reg_we_i,
    input  logic [1:0]        reg_sel_i,
    input  logic [STAT_W-1:0] reg_wdata_i,
    input  logic              cal_req_i,
    output logic [STAT_W-1:0] status_o,
    output logic              irq_o,
    output logic              inf_en_o,
    output logic              stat_en_o,
    output logic              train_o,
    output logic              dp_run_o,
    output logic              credit_flush_o,
    output logic              cal_ok_o
);
    logic               burst_evt;
    logic               fatal;
    logic [NUM_EVT-1:0] evt_eff;
    logic [NUM_EVT-1:0] imask_w;
    logic [NUM_EVT-1:0] fmask_w;

    ters_burst_mon #(
        .MAX_BURST_BYTES(MAX_BURST_BYTES),
        .BEAT_BYTES     (BEAT_BYTES)
    ) u_burst (
        .clk      (clk),
        .rst_n    (rst_n),
        .beat_i   (beat_i),
        .last_i   (beat_last_i),
        .too_big_o(burst_evt)
    );

    for (genvar g = 0; g < NUM_EVT; g++) begin : g_evt
        if (g == EV_BURST_BIG) begin : g_burst
            assign evt_eff[g] = evt_i[g] | burst_evt;
        end else begin : g_plain
            assign evt_eff[g] = evt_i[g];
        end
    end

    ters_evt_status u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_i   (evt_eff),
        .we_i    (reg_we_i),
        .sel_i   (reg_sel_i),
        .wdata_i (reg_wdata_i),
        .status_o(status_o),
        .imask_o (imask_w),
        .fmask_o (fmask_w),
        .irq_o   (irq_o),
        .fatal_o (fatal)
    );

    ters_sync_ctl u_sync (
        .clk           (clk),
        .rst_n         (rst_n),
        .we_i          (reg_we_i),
        .sel_i         (reg_sel_i),
        .ifen_wr_i     (reg_wdata_i[0]),
        .sten_wr_i     (reg_wdata_i[3]),
        .fatal_i       (fatal),
        .syncerr_i     (status_o[SYNCERR_BIT]),
        .cal_req_i     (cal_req_i),
        .inf_en_o      (inf_en_o),
        .stat_en_o     (stat_en_o),
        .train_o       (train_o),
        .dp_run_o      (dp_run_o),
        .credit_flush_o(credit_flush_o),
        .cal_ok_o      (cal_ok_o)
    );
endmodule

// File: rtl/txerr_resync_chk.sv
module txerr_resync_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] evt_eff,
    input logic [7:0] imask,
    input logic [7:0] fmask,
    input logic       reg_we_i,
    input logic [1:0] reg_sel_i,
    input logic [8:0] status_o,
    input logic       irq_o,
    input logic       inf_en_o,
    input logic       train_o,
    input logic       credit_flush_o,
    input logic       cal_ok_o
);
    // R1: every event lands in its status bit on the next edge
    p_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_eff != 8'd0) |=> ((status_o[7:0] & $past(evt_eff)) == $past(evt_eff)));

    // R2: without a status-clear write no set bit drops
    p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we_i && reg_sel_i == 2'd1) |=> ((status_o & $past(status_o)) == $past(status_o)));

    // R3: interrupt follows masked status one cycle later
    p_irq_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == $past(|(status_o[7:0] & imask)));

    // R4: a fatal event forces training and the sync error
    p_fatal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|(evt_eff & fmask)) |=> (train_o && status_o[8]));

    // R5: release only with enable high and sync error clear
    p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(train_o) |-> ($past(inf_en_o) && !$past(status_o[8])));

    // R6: credit flush only right after the enable fell
    p_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
        credit_flush_o |-> (!inf_en_o && $past(inf_en_o)));

    // R7: no calendar grant while enabled
    p_cal_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cal_ok_o |-> !inf_en_o);
endmodule

bind txerr_resync_ctrl txerr_resync_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .evt_eff       (evt_eff),
    .imask         (imask_w),
    .fmask         (fmask_w),
    .reg_we_i      (reg_we_i),
    .reg_sel_i     (reg_sel_i),
    .status_o      (status_o),
    .irq_o         (irq_o),
    .inf_en_o      (inf_en_o),
    .train_o       (train_o),
    .credit_flush_o(credit_flush_o),
    .cal_ok_o      (cal_ok_o)
);

// File: tb/txerr_resync_ctrl_tb_top.sv
module txerr_resync_ctrl_tb_top;
    localparam int LIMIT = 524288 / 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] evt_i = '0;
    logic       beat_i = 1'b0, beat_last_i = 1'b0;
    logic       reg_we_i = 1'b0;
    logic [1:0] reg_sel_i = '0;
    logic [8:0] reg_wdata_i = '0;
    logic       cal_req_i = 1'b0;
    logic [8:0] status_o;
    logic       irq_o, inf_en_o, stat_en_o, train_o, dp_run_o, credit_flush_o, cal_ok_o;

    int  vectors = 0;
    int  miscompares = 0;
    bit  done = 1'b0;

    // bench model state
    logic [8:0] m_st = '0;
    logic [7:0] m_im = '0, m_fm = '0;
    logic       m_irq = 0, m_inf = 0, m_sten = 0, m_train = 0, m_armed = 0, m_flush = 0;
    int         m_cnt = 0;

    always #10 clk = ~clk;

    txerr_resync_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .beat_i(beat_i),
        .beat_last_i(beat_last_i), .reg_we_i(reg_we_i), .reg_sel_i(reg_sel_i),
        .reg_wdata_i(reg_wdata_i), .cal_req_i(cal_req_i), .status_o(status_o),
        .irq_o(irq_o), .inf_en_o(inf_en_o), .stat_en_o(stat_en_o), .train_o(train_o),
        .dp_run_o(dp_run_o), .credit_flush_o(credit_flush_o), .cal_ok_o(cal_ok_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // one clock cycle: drive, model, compare
    task automatic cyc(input logic [7:0] evt, input logic we, input logic [1:0] sel,
                       input logic [8:0] wd, input logic beat, input logic last,
                       input logic cal);
        logic       bevt, fatal;
        logic [7:0] evb;
        logic [8:0] clr, n_st;
        logic       n_inf, n_sten;
        evt_i = evt; reg_we_i = we; reg_sel_i = sel; reg_wdata_i = wd;
        beat_i = beat; beat_last_i = last; cal_req_i = cal;
        #1;
        chk("R7", "cal_ok", 32'(cal_ok_o), 32'(cal & ~m_inf));
        bevt  = beat && (m_cnt == LIMIT);
        evb   = evt | {5'd0, bevt, 2'd0};
        fatal = |(evb & m_fm);
        clr   = (we && sel == 2'd1) ? wd : 9'd0;
        n_st[7:0] = (m_st[7:0] & ~clr[7:0]) | evb;
        n_st[8]   = (m_st[8] & ~clr[8]) | fatal;
        n_inf  = (we && sel == 2'd0) ? wd[0] : m_inf;
        n_sten = (we && sel == 2'd0) ? wd[3] : m_sten;
        m_irq   = |(m_st[7:0] & m_im);
        m_flush = m_inf & ~n_inf;
        m_armed = m_train & ~fatal & (m_armed | (~m_st[8] & ~m_inf)) ;
        m_train = fatal | (m_train & ~(m_armed_prev_and_inf()));
        m_st = n_st;
        if (we && sel == 2'd2) m_im = wd[7:0];
        if (we && sel == 2'd3) m_fm = wd[7:0];
        m_inf = n_inf; m_sten = n_sten;
        if (beat) m_cnt = last ? 0 : ((m_cnt != LIMIT) ? m_cnt + 1 : m_cnt);
        @(posedge clk);
        @(negedge clk);
        chk("R2", "status", 32'(status_o), 32'(m_st));
        chk("R3", "irq", 32'(irq_o), 32'(m_irq));
        chk("R4", "train", 32'(train_o), 32'(m_train));
        chk("R9", "dp_run", 32'(dp_run_o), 32'(m_inf & ~m_train));
        chk("R6", "flush", 32'(credit_flush_o), 32'(m_flush));
        chk("R9", "inf_en", 32'(inf_en_o), 32'(m_inf));
        chk("R9", "stat_en", 32'(stat_en_o), 32'(m_sten));
    endtask

    // release condition uses armed/enable as they were before this edge
    logic m_rel = 1'b0;
    function automatic logic m_armed_prev_and_inf();
        return m_rel;
    endfunction

    task automatic step(input logic [7:0] evt, input logic we, input logic [1:0] sel,
                        input logic [8:0] wd);
        m_rel = m_armed & m_inf;
        cyc(evt, we, sel, wd, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic step_full(input logic [7:0] evt, input logic we, input logic [1:0] sel,
                             input logic [8:0] wd, input logic beat, input logic last,
                             input logic cal);
        m_rel = m_armed & m_inf;
        cyc(evt, we, sel, wd, beat, last, cal);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R10: reset state
        chk("R10", "status", 32'(status_o), 0);
        chk("R10", "irq", 32'(irq_o), 0);
        chk("R10", "train", 32'(train_o), 0);
        chk("R10", "inf_en", 32'(inf_en_o), 0);
        chk("R10", "dp_run", 32'(dp_run_o), 0);
        chk("R10", "flush", 32'(credit_flush_o), 0);
        @(negedge clk);

        // R7: grant while disabled
        step_full(8'd0, 1'b0, 2'd0, 9'd0, 1'b0, 1'b0, 1'b1);
        // R9: enable interface and status channel
        step(8'd0, 1'b1, 2'd0, 9'h009);
        chk("R9", "dp_run after enable", 32'(dp_run_o), 1);
        step_full(8'd0, 1'b0, 2'd0, 9'd0, 1'b0, 1'b0, 1'b1);

        // R1: bit mapping, masks clear
        for (int i = 0; i < 8; i++) begin
            step(8'(1 << i), 1'b0, 2'd0, 9'd0);
            chk("R1", "bit set", 32'(status_o), 32'(1 << i));
            step(8'd0, 1'b1, 2'd1, 9'(1 << i));
            chk("R2", "w1c cleared", 32'(status_o), 0);
        end

        // R2: set beats clear in same cycle
        step(8'h01, 1'b0, 2'd0, 9'd0);
        step(8'h01, 1'b1, 2'd1, 9'h001);
        chk("R2", "set wins", 32'(status_o[0]), 1);
        step(8'd0, 1'b1, 2'd1, 9'h1FF);

        // R3: masked interrupt
        step(8'd0, 1'b1, 2'd2, 9'h010);
        step(8'h20, 1'b0, 2'd0, 9'd0);
        step(8'd0, 1'b0, 2'd0, 9'd0);
        chk("R3", "masked bit no irq", 32'(irq_o), 0);
        step(8'h10, 1'b0, 2'd0, 9'd0);
        step(8'd0, 1'b0, 2'd0, 9'd0);
        chk("R3", "unmasked bit irq", 32'(irq_o), 1);
        step(8'd0, 1'b1, 2'd1, 9'h1FF);

        // R4: fatal mask on bits 3 and 5
        step(8'd0, 1'b1, 2'd3, 9'h028);
        step(8'h10, 1'b0, 2'd0, 9'd0);
        chk("R4", "non-fatal no train", 32'(train_o), 0);
        step(8'h20, 1'b0, 2'd0, 9'd0);
        chk("R4", "fatal train", 32'(train_o), 1);
        chk("R4", "syncerr", 32'(status_o[8]), 1);
        chk("R4", "dp stopped", 32'(dp_run_o), 0);

        // R5: toggle before clearing syncerr keeps training
        step(8'd0, 1'b1, 2'd0, 9'h000);
        chk("R6", "flush on disable", 32'(credit_flush_o), 1);
        step(8'd0, 1'b1, 2'd0, 9'h009);
        step(8'd0, 1'b0, 2'd0, 9'd0);
        step(8'd0, 1'b0, 2'd0, 9'd0);
        chk("R5", "early toggle holds train", 32'(train_o), 1);
        // correct order
        step(8'd0, 1'b1, 2'd1, 9'h100);
        step(8'd0, 1'b1, 2'd0, 9'h000);
        step(8'd0, 1'b0, 2'd0, 9'd0);
        step(8'd0, 1'b1, 2'd0, 9'h009);
        step(8'd0, 1'b0, 2'd0, 9'd0);
        chk("R5", "released", 32'(train_o), 0);
        chk("R5", "running", 32'(dp_run_o), 1);

        // random mix
        void'($urandom(32'd1234));
        for (int n = 0; n < 3000; n++) begin
            logic [7:0] ev;
            logic       w;
            ev = ($urandom % 8 == 0) ? 8'($urandom) : 8'd0;
            w  = ($urandom % 6 == 0);
            step_full(ev, w, 2'($urandom), 9'($urandom),
                      1'($urandom), ($urandom % 16 == 0), 1'($urandom));
        end

        // R8: burst boundary
        step(8'd0, 1'b1, 2'd3, 9'h000);
        step(8'd0, 1'b1, 2'd1, 9'h1FF);
        step_full(8'd0, 1'b0, 2'd0, 9'd0, 1'b1, 1'b1, 1'b0);
        for (int b = 1; b <= LIMIT; b++)
            step_full(8'd0, 1'b0, 2'd0, 9'd0, 1'b1, (b == LIMIT), 1'b0);
        chk("R8", "exact limit no event", 32'(status_o[2]), 0);
        for (int b = 1; b <= LIMIT + 1; b++)
            step_full(8'd0, 1'b0, 2'd0, 9'd0, 1'b1, (b == LIMIT + 1), 1'b0);
        chk("R8", "over limit event", 32'(status_o[2]), 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule